// File: doc/BRIEF.md
# I2C Event Status and Interrupt Vector Unit

This unit sits beside an I2C bus engine and turns the engine's single-cycle event pulses into sticky status flags. The seven events are arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, stop detected and addressed as slave. A separate enable mask gates the flags. The unit reports the most urgent enabled flag as a 3-bit code in a vector register and drives one registered interrupt line.

Software reads the vector register in a loop until it returns zero, and handles one event per read. A vector read retires the event it reports. The receive-ready and transmit-ready flags are the exception: they stay set until the data path moves a byte. The status register also shows two live bus conditions, bus busy and receive shift full, which software can read but cannot change.

Top module: `i2c_event_vector`

## Requirements
- R1: After reset all seven flags, the mask register and the interrupt line are 0, and the vector reads 0.
- R2: A one-cycle pulse on `evt_i[k]` sets status flag k, whatever the mask. The positions are: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave. Mask bit k uses the same position.
- R3: The vector reads k+1 for the reported flag k, so the codes run from 1 (arbitration lost) to 7 (addressed as slave). It reads 0 when no flag is both set and enabled.
- R4: When several enabled flags are pending, the vector reports the one with the lowest code.
- R5: A vector read (`reg_rd` with `reg_sel`=2) clears the flag it reports, except for codes 4 and 5, which it leaves set.
- R6: Writing the status register (`reg_sel`=1) with a 1 at bit 0, 1, 2, 3, 5 or 6 clears that flag. A 0 bit has no effect.
- R7: A status write cannot clear transmit ready (bit 4). A `tx_data_loaded` pulse clears it. An `rx_data_taken` pulse clears receive ready (bit 3).
- R8: Status bit 12 mirrors `bus_busy_i` and bit 11 mirrors `rx_shift_full_i`. A write leaves both unchanged.
- R9: `irq_o` rises one clock after an enabled flag becomes pending. It falls one clock after none is pending.
- R10: If an event pulse and a clearing action hit the same flag in the same cycle, the flag ends up set.
- R11: `reg_sel` 0 selects the mask register. Its bits 6:0 are writable and its upper bits read 0. `reg_sel` 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Event pulses from the bus engine, one bit per event |
| rx_data_taken | input | 1 | A received byte was read; clears receive ready |
| tx_data_loaded | input | 1 | A byte was loaded for sending; clears transmit ready |
| bus_busy_i | input | 1 | Live bus-busy condition |
| rx_shift_full_i | input | 1 | Live receive-shift-full condition |
| reg_sel | input | 2 | Register select: 0 mask, 1 status, 2 vector |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects on vector reads) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The vector path is tried with three kinds of input:
- A single flag that is disabled and then enabled. This separates the status view from the gated view.
- A mixed set of no-acknowledge, stop and addressed-as-slave, drained by repeated vector reads. This shows whether the ordering runs lowest code first and whether each read retires exactly one event.
- Receive ready and transmit ready, read twice each. This shows whether a vector read wrongly clears them, and whether only their data strobes do.

Separate patterns cover the following:
- Write-one-to-clear against zero writes.
- A pulse that arrives in the same cycle as a clear.
- The one-cycle lag of the interrupt line in both directions.

// File: rtl/i2c_event_pkg.sv
package i2c_event_pkg;
    localparam int EV_NUM    = 7;
    localparam int EV_ARBL   = 0;
    localparam int EV_NOACK  = 1;
    localparam int EV_ACCRDY = 2;
    localparam int EV_RXRDY  = 3;
    localparam int EV_TXRDY  = 4;
    localparam int EV_STOP   = 5;
    localparam int EV_ADDR   = 6;

    // flags that a status write may clear (transmit ready excluded)
    localparam logic [EV_NUM-1:0] SW_CLR_OK   = ~(EV_NUM'(1) << EV_TXRDY);
    // flags a vector read leaves untouched
    localparam logic [EV_NUM-1:0] VEC_RD_KEEP = (EV_NUM'(1) << EV_RXRDY) | (EV_NUM'(1) << EV_TXRDY);

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_STAT = 2'd1,
        SEL_VEC  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/i2c_event_flags.sv
module i2c_event_flags #(
    parameter int NEV = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] set_i,
    input  logic [NEV-1:0] clr_i,
    output logic [NEV-1:0] flags_o
);
    typedef struct packed {
        logic [NEV-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a fresh event wins over any clear in the same cycle
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    for (genvar k = 0; k < NEV; k++) begin : g_flag_chk
        p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flags_o[k]);
        p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flags_o[k]);
        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[k] && !clr_i[k]) |=> flags_o[k]);
    end
endmodule

// File: rtl/i2c_event_prio.sv
module i2c_event_prio #(
    parameter int NEV = 7,
    localparam int VW = $clog2(NEV + 1)
) (
    input  logic [NEV-1:0] pend_i,
    output logic [VW-1:0]  code_o
);
    always_comb begin
        code_o = '0;
        for (int i = NEV - 1; i >= 0; i--) begin
            if (pend_i[i]) code_o = VW'(i + 1);
        end
    end
endmodule

// File: rtl/i2c_event_vector.sv
module i2c_event_vector
    import i2c_event_pkg::*;
#(
    parameter int DW      = 16,
    parameter int BB_BIT  = 12,
    parameter int RSF_BIT = 11,
    localparam int NEV    = EV_NUM,
    localparam int VW     = $clog2(NEV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NEV-1:0] evt_i,
    input  logic          rx_data_taken,
    input  logic          tx_data_loaded,
    input  logic          bus_busy_i,
    input  logic          rx_shift_full_i,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_o
);
    typedef struct packed {
        logic [NEV-1:0] mask;
        logic           irq;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NEV-1:0] flags;
    logic [NEV-1:0] pend;
    logic [VW-1:0]  vec_code;
    logic [NEV-1:0] clr_sw, clr_vec, clr_data, clr_all;
    logic           wr_mask, wr_stat, rd_vec;
    logic           unused_wbits;

    assign wr_mask = reg_wr && (reg_sel == SEL_MASK);
    assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
    assign rd_vec  = reg_rd && (reg_sel == SEL_VEC);
    assign unused_wbits = ^reg_wdata[DW-1:NEV];

    assign pend = flags & st_q.mask;

    i2c_event_prio #(.NEV(NEV)) u_prio (
        .pend_i (pend),
        .code_o (vec_code)
    );

    always_comb begin
        clr_sw = wr_stat ? (reg_wdata[NEV-1:0] & SW_CLR_OK) : '0;
        clr_vec = '0;
        for (int i = 0; i < NEV; i++) begin
            if (rd_vec && (vec_code == VW'(i + 1)) && !VEC_RD_KEEP[i])
                clr_vec[i] = 1'b1;
        end
        clr_data = '0;
        clr_data[EV_RXRDY] = rx_data_taken;
        clr_data[EV_TXRDY] = tx_data_loaded;
        clr_all = clr_sw | clr_vec | clr_data;
    end

    i2c_event_flags #(.NEV(NEV)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_i),
        .clr_i   (clr_all),
        .flags_o (flags)
    );

    always_comb begin
        st_d = st_q;
        if (wr_mask) st_d.mask = reg_wdata[NEV-1:0];
        st_d.irq = |pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_MASK: reg_rdata[NEV-1:0] = st_q.mask;
            SEL_STAT: begin
                reg_rdata[NEV-1:0] = flags;
                reg_rdata[RSF_BIT] = rx_shift_full_i;
                reg_rdata[BB_BIT]  = bus_busy_i;
            end
            SEL_VEC:  reg_rdata[VW-1:0] = vec_code;
            default:  reg_rdata = '0;
        endcase
    end

    // interrupt follows the vector by one clock
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |=> irq_o);
    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code == '0) |=> !irq_o);
    // no enabled flag below the reported one
    p_lowest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |-> ((pend & ((NEV'(1) << (vec_code - 1'b1)) - NEV'(1))) == '0));
    p_code_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |-> pend[vec_code - 1'b1]);
    p_vec_rd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && vec_code == VW'(EV_ARBL + 1) && !evt_i[EV_ARBL]) |=> !flags[EV_ARBL]);
    p_txrdy_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[EV_TXRDY] && flags[EV_TXRDY] && !tx_data_loaded) |=> flags[EV_TXRDY]);
endmodule

// File: tb/i2c_event_vector_tb.sv
module i2c_event_vector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_i = '0;
    logic        rx_data_taken = 1'b0;
    logic        tx_data_loaded = 1'b0;
    logic        bus_busy_i = 1'b0;
    logic        rx_shift_full_i = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    i2c_event_vector dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .rx_data_taken(rx_data_taken), .tx_data_loaded(tx_data_loaded),
        .bus_busy_i(bus_busy_i), .rx_shift_full_i(rx_shift_full_i),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_ev(input logic [6:0] m);
        @(negedge clk);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic clear_all();
        wr(2'd1, 16'h007F);
        @(negedge clk); tx_data_loaded = 1'b1;
        @(negedge clk); tx_data_loaded = 1'b0;
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd1, v); check("R1 status", v, 16'h0000);
        rd(2'd0, v); check("R1 mask", v, 16'h0000);
        rd(2'd2, v); check("R1 vector", v, 16'h0000);
        check("R1 irq", {15'd0, irq_o}, 16'h0000);
    endtask

    task automatic t_mask_gate();
        logic [15:0] v;
        pulse_ev(7'h01);
        rd(2'd1, v); check("R2 arb flag set while masked", v, 16'h0001);
        rd(2'd2, v); check("R3 vector zero when masked", v, 16'h0000);
        check("R9 irq low when masked", {15'd0, irq_o}, 16'h0000);
        wr(2'd0, 16'h0001);
        check("R9 irq still low right after mask write", {15'd0, irq_o}, 16'h0000);
        @(negedge clk);
        check("R9 irq high one clock later", {15'd0, irq_o}, 16'h0001);
        wr(2'd0, 16'h0000);
        check("R9 irq lags mask clear", {15'd0, irq_o}, 16'h0001);
        @(negedge clk);
        check("R9 irq falls", {15'd0, irq_o}, 16'h0000);
        wr(2'd0, 16'h0001);
        rd(2'd2, v); check("R3 arb code 1", v, 16'h0001);
        rd(2'd1, v); check("R5 vector read cleared arb", v, 16'h0000);
        clear_all();
    endtask

    task automatic t_priority();
        logic [15:0] v;
        wr(2'd0, 16'h007F);
        pulse_ev(7'h62);
        rd(2'd2, v); check("R4 first noack", v, 16'h0002);
        rd(2'd2, v); check("R4 then stop", v, 16'h0006);
        rd(2'd2, v); check("R4 then addressed", v, 16'h0007);
        rd(2'd2, v); check("R3 drained to zero", v, 16'h0000);
        pulse_ev(7'h04);
        rd(2'd2, v); check("R3 access ready code 3", v, 16'h0003);
        clear_all();
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        pulse_ev(7'h67);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); check("R6 zero write no effect", v, 16'h0067);
        wr(2'd1, 16'h0024);
        rd(2'd1, v); check("R6 clear access ready and stop", v, 16'h0043);
        wr(2'd1, 16'h0043);
        rd(2'd1, v); check("R6 clear rest", v, 16'h0000);
        clear_all();
    endtask

    task automatic t_rx_tx();
        logic [15:0] v;
        wr(2'd0, 16'h007F);
        pulse_ev(7'h08);
        rd(2'd2, v); check("R3 rx code 4", v, 16'h0004);
        rd(2'd2, v); check("R5 rx kept after vector read", v, 16'h0004);
        @(negedge clk); rx_data_taken = 1'b1;
        @(negedge clk); rx_data_taken = 1'b0;
        rd(2'd1, v); check("R7 rx cleared by data read", v, 16'h0000);
        pulse_ev(7'h08);
        wr(2'd1, 16'h0008);
        rd(2'd1, v); check("R6 rx cleared by status write", v, 16'h0000);
        pulse_ev(7'h10);
        wr(2'd1, 16'h0010);
        rd(2'd1, v); check("R7 tx not write clearable", v, 16'h0010);
        rd(2'd2, v); check("R3 tx code 5", v, 16'h0005);
        rd(2'd2, v); check("R5 tx kept after vector read", v, 16'h0005);
        @(negedge clk); tx_data_loaded = 1'b1;
        @(negedge clk); tx_data_loaded = 1'b0;
        rd(2'd1, v); check("R7 tx cleared by data load", v, 16'h0000);
        clear_all();
    endtask

    task automatic t_live_bits();
        logic [15:0] v;
        @(negedge clk); bus_busy_i = 1'b1; rx_shift_full_i = 1'b1;
        rd(2'd1, v); check("R8 live bits shown", v, 16'h1800);
        wr(2'd1, 16'h1800);
        rd(2'd1, v); check("R8 live bits survive write", v, 16'h1800);
        @(negedge clk); bus_busy_i = 1'b0; rx_shift_full_i = 1'b0;
        rd(2'd1, v); check("R8 live bits follow inputs", v, 16'h0000);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        @(negedge clk);
        evt_i = 7'h04; reg_sel = 2'd1; reg_wdata = 16'h0004; reg_wr = 1'b1;
        @(negedge clk);
        evt_i = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd1, v); check("R10 set beats clear", v, 16'h0004);
        clear_all();
    endtask

    task automatic t_mask_reg();
        logic [15:0] v;
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); check("R11 mask readback", v, 16'h007F);
        rd(2'd3, v); check("R11 unused select", v, 16'h0000);
        wr(2'd0, 16'h0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_gate();
        t_priority();
        t_w1c();
        t_rx_tx();
        t_live_bits();
        t_set_wins();
        t_mask_reg();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule